// File: doc/BRIEF.md
# Edge-Phase Signature Demodulator and Checker

This receive-side block recovers a hidden authentication signature from the timing of edges in a received NRZ bit stream. It then checks that signature against an expected value. The block runs on a quantum clock, where one bit lasts `QUANTA_PER_BIT` cycles. A reference bit phase is locked to the start-of-frame falling edge. The phase of every later data edge is then measured against that reference in whole quanta. A transmitter encodes a signature 1 by delaying an edge by a few quanta. It encodes a 0 by leaving the edge on time.

A frame-window enable marks the payload bits that carry signature information. Within that window, the bits are grouped five at a time, and each group yields one signature bit. Edges that arrive close to the reference realign it, so slow drift between transmitter and receiver clocks is absorbed during the frame.

When the frame ends, the recovered bits are compared with the locally generated expected signature, over 8 or 16 bits. The outcome is presented as a registered pass/fail result. That result stays in place until the next frame begins.

Top module: `edge_phase_sig_checker`

## Requirements
- R1: While idle, a falling edge on `rxData` (high in the previous cycle, low now) starts a frame, and the reference phase of that cycle is 0. One cycle later `resValid`, `goNoGo`, `edgeMissErr` and `sigOut` read 0.
- R2: The phase of an edge is the number of quantum cycles since the last reference bit boundary. An in-window edge with a phase from 2 up to `QUANTA_PER_BIT`-2 decodes as 1. Phases 0 and 1 decode as 0.
- R3: An edge with a phase of 0, 1 or `QUANTA_PER_BIT`-1 realigns the reference so that the edge's cycle becomes phase 0. An edge at phase `QUANTA_PER_BIT`-1 counts as early and decodes as 0. With this realignment, edges that drift one quantum later in every group still decode as 0.
- R4: Reference bit boundaries that occur while `frameEn` is high are counted in groups of five. The first in-window edge of group i sets `sigOut[i]`. Later edges in the same group have no effect.
- R5: An edge that occurs while `frameEn` is low is not decoded. It does not set a signature bit.
- R6: If a complete group whose index is below the signature length contains no in-window edge, `edgeMissErr` is set and the frame result is NO_GO (`goNoGo`=0).
- R7: `sigLen16` is sampled only while `rstN` is low. A value of 1 selects 16 signature bits and 0 selects 8. Changing the input after reset has no effect. Groups at or beyond the length leave `sigOut` bits at or above the length at 0.
- R8: In the cycle after a `frameEnd` pulse inside a frame, `resValid` is 1. In that same cycle, `goNoGo`=1 only if three conditions all hold: no group was missed, the number of recovered bits is at least the length, and `sigOut` equals `expSig` over the low length bits.
- R9: A frame that ends before as many bits as the selected length have been recovered gives NO_GO.
- R10: `resValid`, `goNoGo` and `sigOut` hold until the cycle after the next start of frame. A `frameEnd` pulse while idle is ignored.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quantum clock, one cycle per time quantum |
| rstN | input | 1 | Synchronous active-low reset |
| rxData | input | 1 | Received single-rail NRZ data |
| frameEn | input | 1 | High over the payload bits that carry signature edges |
| frameEnd | input | 1 | One-cycle pulse at the end of the frame |
| sigLen16 | input | 1 | Length select sampled during reset: 1 = 16 bits, 0 = 8 bits |
| expSig | input | SIG_MAX | Expected signature, bit i for group i |
| sigOut | output | SIG_MAX | Recovered signature, bit i from group i |
| resValid | output | 1 | Frame result valid |
| goNoGo | output | 1 | 1 = signature match (GO), 0 = NO_GO |
| edgeMissErr | output | 1 | A group inside the length had no edge |

## Verification
Suppose the reference phase drifts by a single quantum. A wrong realignment then turns a 0 into a 1, or the reverse. The error appears in `sigOut` in the cycle after the decoding edge, long before `goNoGo` is registered at frame end. A wrong group counter shows up instead as a bit written to the neighbouring `sigOut` position, or as a spurious `edgeMissErr` one cycle after a group closes. Because the behavioural model is compared against the design on every clock, such faults are caught at the first cycle they become visible, not only at the frame result.

// File: rtl/epsc_pkg.sv
package epsc_pkg;
  // Strobes handed from the phase control to the signature datapath.
  typedef struct packed {
    logic sofStb;   // start of frame seen this cycle
    logic edgeStb;  // data edge inside an active frame
    logic edgeBit;  // decoded value of that edge
    logic wrapStb;  // reference bit boundary (normal or early realign)
    logic doneStb;  // end of frame accepted
  } epsdStrobes_t;
endpackage

// File: rtl/epsc_phase_ctrl.sv
module epsc_phase_ctrl
  import epsc_pkg::*;
#(
  parameter int QUANTA_PER_BIT = 25,
  parameter int PHASE_THRESH   = 2,
  parameter int EARLY_WIN      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxData,
  input  logic         frameEnd,
  output epsdStrobes_t strobes,
  output logic         inFrame
);
  localparam int PH_W = $clog2(QUANTA_PER_BIT);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(QUANTA_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_THR   = PH_W'(PHASE_THRESH);
  localparam logic [PH_W-1:0] PH_EARLY = PH_W'(QUANTA_PER_BIT - EARLY_WIN);

  logic            prevData;
  logic            inFrameQ;
  logic [PH_W-1:0] phaseCnt;

  logic edgeNow, sofNow, phLate, phEarly, realign;

  always_comb begin
    edgeNow = rxData ^ prevData;
    sofNow  = !inFrameQ && prevData && !rxData;
    phLate  = phaseCnt < PH_THR;
    phEarly = phaseCnt >= PH_EARLY;
    realign = inFrameQ && edgeNow && (phLate || phEarly);

    strobes.sofStb  = sofNow;
    strobes.edgeStb = inFrameQ && edgeNow;
    strobes.edgeBit = !phLate && !phEarly;
    strobes.wrapStb = inFrameQ && ((phaseCnt == PH_LAST) || (edgeNow && phEarly));
    strobes.doneStb = inFrameQ && frameEnd;
  end

  assign inFrame = inFrameQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevData <= 1'b1;
      inFrameQ <= 1'b0;
      phaseCnt <= '0;
    end else begin
      prevData <= rxData;
      if (sofNow) begin
        inFrameQ <= 1'b1;
        phaseCnt <= PH_W'(1);
      end else if (inFrameQ) begin
        if (frameEnd) inFrameQ <= 1'b0;
        if (realign)                 phaseCnt <= PH_W'(1);
        else if (phaseCnt == PH_LAST) phaseCnt <= '0;
        else                          phaseCnt <= phaseCnt + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/epsc_sig_datapath.sv
module epsc_sig_datapath
  import epsc_pkg::*;
#(
  parameter int GROUP_BITS = 5,
  parameter int SIG_MAX    = 16,
  parameter int SIG_MIN    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sigLen16,
  input  logic               frameEn,
  input  logic [SIG_MAX-1:0] expSig,
  input  epsdStrobes_t       strobes,
  output logic [SIG_MAX-1:0] sigOut,
  output logic               resValid,
  output logic               goNoGo,
  output logic               edgeMissErr
);
  localparam int GI_W = $clog2(SIG_MAX + 1);
  localparam int BI_W = (GROUP_BITS > 1) ? $clog2(GROUP_BITS) : 1;
  localparam logic [BI_W-1:0] BI_LAST = BI_W'(GROUP_BITS - 1);

  logic               len16Q;
  logic [BI_W-1:0]    bitInGrp;
  logic [GI_W-1:0]    grpIdx;
  logic               seen;
  logic [SIG_MAX-1:0] sigReg;
  logic [GI_W-1:0]    nGot;
  logic               errQ;
  logic               validQ;
  logic               goQ;

  logic [GI_W-1:0]    lenN;
  logic [SIG_MAX-1:0] lenMask;
  logic               winWrap, closeGrp, winEdge, missNow, takeBit;
  logic [BI_W-1:0]    postBit;
  logic [GI_W-1:0]    postGrp;
  logic               postSeen;
  logic [SIG_MAX-1:0] sigNext;
  logic [GI_W-1:0]    gotNext;
  logic               errNext, goNext;

  always_comb begin
    lenN = len16Q ? GI_W'(SIG_MAX) : GI_W'(SIG_MIN);
    for (int i = 0; i < SIG_MAX; i++) lenMask[i] = (GI_W'(i) < lenN);

    // Group bookkeeping happens before the edge is applied, so an early
    // edge that closes a bit lands in the group that follows.
    winWrap  = strobes.wrapStb && frameEn;
    closeGrp = winWrap && (bitInGrp == BI_LAST);
    missNow  = closeGrp && !seen && (grpIdx < lenN);
    if (closeGrp)     postBit = '0;
    else if (winWrap) postBit = bitInGrp + BI_W'(1);
    else              postBit = bitInGrp;
    postGrp  = (closeGrp && (grpIdx < GI_W'(SIG_MAX))) ? grpIdx + GI_W'(1) : grpIdx;
    postSeen = closeGrp ? 1'b0 : seen;

    winEdge = strobes.edgeStb && frameEn;
    takeBit = winEdge && !postSeen && (postGrp < lenN);

    sigNext = sigReg;
    for (int i = 0; i < SIG_MAX; i++)
      if (takeBit && (postGrp == GI_W'(i))) sigNext[i] = strobes.edgeBit;
    gotNext = nGot + {{(GI_W-1){1'b0}}, takeBit};
    errNext = errQ || missNow;
    goNext  = !errNext && (gotNext >= lenN) && (((sigNext ^ expSig) & lenMask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      len16Q   <= sigLen16;
      bitInGrp <= '0;
      grpIdx   <= '0;
      seen     <= 1'b0;
      sigReg   <= '0;
      nGot     <= '0;
      errQ     <= 1'b0;
      validQ   <= 1'b0;
      goQ      <= 1'b0;
    end else if (strobes.sofStb) begin
      bitInGrp <= '0;
      grpIdx   <= '0;
      seen     <= 1'b0;
      sigReg   <= '0;
      nGot     <= '0;
      errQ     <= 1'b0;
      validQ   <= 1'b0;
      goQ      <= 1'b0;
    end else begin
      bitInGrp <= postBit;
      grpIdx   <= postGrp;
      seen     <= postSeen || winEdge;
      sigReg   <= sigNext;
      nGot     <= gotNext;
      errQ     <= errNext;
      if (strobes.doneStb) begin
        validQ <= 1'b1;
        goQ    <= goNext;
      end
    end
  end

  assign sigOut      = sigReg;
  assign resValid    = validQ;
  assign goNoGo      = goQ;
  assign edgeMissErr = errQ;
endmodule

// File: rtl/edge_phase_sig_checker.sv
module edge_phase_sig_checker
  import epsc_pkg::*;
#(
  parameter int QUANTA_PER_BIT = 25,
  parameter int PHASE_THRESH   = 2,
  parameter int EARLY_WIN      = 1,
  parameter int GROUP_BITS     = 5,
  parameter int SIG_MAX        = 16,
  parameter int SIG_MIN        = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxData,
  input  logic               frameEn,
  input  logic               frameEnd,
  input  logic               sigLen16,
  input  logic [SIG_MAX-1:0] expSig,
  output logic [SIG_MAX-1:0] sigOut,
  output logic               resValid,
  output logic               goNoGo,
  output logic               edgeMissErr
);
  epsdStrobes_t strobes;
  logic         inFrame;

  epsc_phase_ctrl #(
    .QUANTA_PER_BIT(QUANTA_PER_BIT),
    .PHASE_THRESH  (PHASE_THRESH),
    .EARLY_WIN     (EARLY_WIN)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rxData  (rxData),
    .frameEnd(frameEnd),
    .strobes (strobes),
    .inFrame (inFrame)
  );

  epsc_sig_datapath #(
    .GROUP_BITS(GROUP_BITS),
    .SIG_MAX   (SIG_MAX),
    .SIG_MIN   (SIG_MIN)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sigLen16   (sigLen16),
    .frameEn    (frameEn),
    .expSig     (expSig),
    .strobes    (strobes),
    .sigOut     (sigOut),
    .resValid   (resValid),
    .goNoGo     (goNoGo),
    .edgeMissErr(edgeMissErr)
  );
endmodule

// File: rtl/epsc_checker.sv
module epsc_checker #(
  parameter int SIG_MAX = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inFrame,
  input logic               sofStb,
  input logic               doneStb,
  input logic [SIG_MAX-1:0] sigOut,
  input logic               resValid,
  input logic               goNoGo,
  input logic               edgeMissErr
);
  assert_sof_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |=> (!resValid && !goNoGo && !edgeMissErr && sigOut == '0));

  assert_sof_only_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |-> !inFrame);

  assert_miss_forces_nogo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && edgeMissErr) |-> !goNoGo);

  assert_result_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> (resValid && !inFrame));

  assert_go_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    goNoGo |-> resValid);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !sofStb) |=> (resValid && $stable(goNoGo) && $stable(sigOut)));
endmodule

bind edge_phase_sig_checker epsc_checker #(.SIG_MAX(SIG_MAX)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inFrame    (inFrame),
  .sofStb     (strobes.sofStb),
  .doneStb    (strobes.doneStb),
  .sigOut     (sigOut),
  .resValid   (resValid),
  .goNoGo     (goNoGo),
  .edgeMissErr(edgeMissErr)
);

// File: tb/edge_phase_sig_checker_tb_top.sv
`timescale 1ns/1ps
module edge_phase_sig_checker_tb_top;
  localparam int QPB    = 25;
  localparam int NOEDGE = -1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxData = 1'b1;
  logic        frameEn = 1'b0;
  logic        frameEnd = 1'b0;
  logic        sigLen16 = 1'b0;
  logic [15:0] expSig = '0;
  logic [15:0] sigOut;
  logic        resValid, goNoGo, edgeMissErr;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  int grpOff [16];
  int edges[$];

  always #2 clk = ~clk;

  edge_phase_sig_checker dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .frameEn(frameEn),
    .frameEnd(frameEnd), .sigLen16(sigLen16), .expSig(expSig),
    .sigOut(sigOut), .resValid(resValid), .goNoGo(goNoGo),
    .edgeMissErr(edgeMissErr)
  );

  // ---------------- behavioural reference model ----------------
  bit          mIn, mPrev, mSeen, mErr, mValid, mGo, mLen16;
  int          mPh, mBit, mGrp, mGot, mLen;
  logic [15:0] mSig;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mLen16 = sigLen16; mLen = sigLen16 ? 16 : 8;
      mIn = 0; mPrev = 1; mPh = 0; mBit = 0; mGrp = 0; mSeen = 0;
      mSig = '0; mGot = 0; mErr = 0; mValid = 0; mGo = 0;
    end else begin
      bit edgeNow, sofNow, late, early, wrap;
      int ph;
      edgeNow = (rxData != mPrev);
      sofNow  = !mIn && mPrev && !rxData;
      mPrev   = rxData;
      ph      = mPh;
      if (sofNow) begin
        mIn = 1; mPh = 1; mBit = 0; mGrp = 0; mSeen = 0;
        mSig = '0; mGot = 0; mErr = 0; mValid = 0; mGo = 0;
      end else if (mIn) begin
        late  = edgeNow && (ph < 2);
        early = edgeNow && (ph >= QPB - 1);
        wrap  = (ph == QPB - 1) || early;
        if (wrap && frameEn) begin
          if (mBit == 4) begin
            if (!mSeen && mGrp < mLen) mErr = 1;
            mBit = 0; if (mGrp < 16) mGrp++; mSeen = 0;
          end else mBit++;
        end
        if (edgeNow && frameEn) begin
          if (!mSeen && mGrp < mLen) begin
            mSig[mGrp] = !(late || early); mGot++;
          end
          mSeen = 1;
        end
        mPh = (late || early) ? 1 : ((ph == QPB - 1) ? 0 : ph + 1);
        if (frameEnd) begin
          logic [15:0] mask;
          mask = (mLen == 16) ? 16'hFFFF : 16'h00FF;
          mIn = 0; mValid = 1;
          mGo = !mErr && (mGot >= mLen) && (((mSig ^ expSig) & mask) == 0);
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      vectors++;
      if (resValid !== mValid || goNoGo !== mGo || edgeMissErr !== mErr || sigOut !== mSig) begin
        miscompares++;
        $display("FAIL model R8/R4 cyc %0d: act v=%0b g=%0b e=%0b s=%h exp v=%0b g=%0b e=%0b s=%h",
                 cycles, resValid, goNoGo, edgeMissErr, sigOut, mValid, mGo, mErr, mSig);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic lvl(input int c);
    int n = 0;
    if (c < 0) return 1'b1;
    foreach (edges[i]) if (edges[i] <= c) n++;
    return ~n[0];
  endfunction

  task automatic stdOffsets(input logic [15:0] sig);
    for (int g = 0; g < 16; g++) grpOff[g] = sig[g] ? 3 : 0;
  endtask

  task automatic buildEdges(input int nG);
    edges.delete();
    edges.push_back(0);
    for (int g = 0; g < nG; g++)
      if (grpOff[g] != NOEDGE) edges.push_back(75 + 125 * g + grpOff[g]);
  endtask

  task automatic runFrame(input int nG, input logic [15:0] exp);
    int endC;
    endC = QPB * (1 + 5 * nG) + 5;
    expSig = exp;
    for (int c = -3; c <= endC + 2; c++) begin
      @(negedge clk);
      if (c == 2) chk("R1 valid cleared after start of frame", {31'd0, resValid}, 32'd0);
      rxData   = lvl(c);
      frameEn  = (c >= QPB) && (c <= endC);
      frameEnd = (c == endC);
    end
    frameEn = 1'b0; frameEnd = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset(input logic len16);
    cmpOn = 1'b0;
    rstN = 1'b0; sigLen16 = len16; rxData = 1'b1; frameEn = 0; frameEnd = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sigLen16 = ~len16;   // must be ignored after reset
    cmpOn = 1'b1;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    doReset(1'b0);
    chk("R11 reset valid", {31'd0, resValid}, 32'd0);
    chk("R11 reset go", {31'd0, goNoGo}, 32'd0);
    chk("R11 reset err/sig", {15'd0, edgeMissErr, sigOut}, 32'd0);

    // 10 groups in 8-bit mode: groups 8,9 ignored
    stdOffsets(16'h03A5); buildEdges(10); runFrame(10, 16'h00A5);
    chk("R8 matching signature gives GO", {31'd0, goNoGo}, 32'd1);
    chk("R8 valid after end", {31'd0, resValid}, 32'd1);
    chk("R7 bits beyond 8 stay zero, R2 decode", {16'd0, sigOut}, 32'h00A5);

    stdOffsets(16'h00A5); buildEdges(8); runFrame(8, 16'h00A4);
    chk("R8 mismatch gives NO_GO", {31'd0, goNoGo}, 32'd0);
    chk("R4 recovered bits on mismatch", {16'd0, sigOut}, 32'h00A5);

    grpOff = '{1, 3, 2, 4, 2, 5, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0};
    buildEdges(8); runFrame(8, 16'h00AA);
    chk("R2 threshold boundary and R3 early edge decode", {16'd0, sigOut}, 32'h00AA);
    chk("R3 threshold frame GO", {31'd0, goNoGo}, 32'd1);

    for (int g = 0; g < 16; g++) grpOff[g] = g + 1;
    buildEdges(8); runFrame(8, 16'h0000);
    chk("R3 cumulative drift absorbed", {16'd0, sigOut}, 32'h0000);
    chk("R3 drift frame GO", {31'd0, goNoGo}, 32'd1);

    stdOffsets(16'h00A4); buildEdges(8);
    edges.push_back(10);            // outside window, would read 1
    edges.push_back(235);           // second edge in group 1, would read 1
    runFrame(8, 16'h00A4);
    chk("R5 pre-window edge ignored", {31'd0, sigOut[0]}, 32'd0);
    chk("R4 later edge in group ignored", {31'd0, sigOut[1]}, 32'd0);
    chk("R5 R4 frame GO", {31'd0, goNoGo}, 32'd1);

    stdOffsets(16'h00A5); grpOff[3] = NOEDGE; buildEdges(8); runFrame(8, 16'h00A5);
    chk("R6 missing edge flagged", {31'd0, edgeMissErr}, 32'd1);
    chk("R6 missing edge forces NO_GO", {31'd0, goNoGo}, 32'd0);

    stdOffsets(16'h00A5); buildEdges(5); runFrame(5, 16'h0005);
    chk("R9 short frame NO_GO", {31'd0, goNoGo}, 32'd0);
    chk("R9 short frame bits", {16'd0, sigOut}, 32'h0005);

    @(negedge clk); frameEnd = 1'b1; @(negedge clk); frameEnd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 idle frameEnd ignored, valid held", {31'd0, resValid}, 32'd1);
    chk("R10 idle frameEnd ignored, result held", {15'd0, goNoGo, sigOut}, 32'h00005);

    doReset(1'b1);
    stdOffsets(16'h5A3C); buildEdges(16); runFrame(16, 16'h5A3C);
    chk("R7 16-bit signature GO", {31'd0, goNoGo}, 32'd1);
    chk("R7 16-bit recovered", {16'd0, sigOut}, 32'h5A3C);

    stdOffsets(16'h5A3C); buildEdges(16); runFrame(16, 16'hDA3C);
    chk("R7 upper byte compared", {31'd0, goNoGo}, 32'd0);

    stdOffsets(16'h003C); buildEdges(8); runFrame(8, 16'h003C);
    chk("R9 8 groups short in 16-bit mode", {31'd0, goNoGo}, 32'd0);

    finish();
  end
endmodule